// File: doc/BRIEF.md
# Half-Step Clock Divider

This block derives a slower clock from a source clock, with the divide ratio chosen in half steps. A divider code `h` selects an output period of `h+1` half-periods of the source clock, so the output runs at `2*f_in/(h+1)`. The available ratios are therefore 1, 1.5, 2, 2.5, 3 and upward. For odd `h+1` the output has to change on falling source edges as well as rising ones. The block does this by working on a grid of half-periods.

Codes 0 and 1 both give an output at the source frequency, in phase with the source. A control block drives the code, and the code may change at any time. The divider takes a new code only when the running output period ends, so it never produces a truncated pulse. Besides the divided clock, the block gives a one-source-cycle enable pulse. Logic that stays on the source clock can use that pulse to act once per output period.

Top module: `halfstep_clkdiv`

## Requirements
- R1: While `rst_ni` is low, `clk_o` and `ce_o` are low. Asserting `rst_ni` takes effect without waiting for a clock edge, and it clears the half-period position counter.
- R2: For a code `h` of 1 or more, the output period is `(h+1)` half-periods of `clk_i`, which is `(h+1)*10 ns` with a 20 ns source clock.
- R3: Code 0 is bypass. `clk_o` has the same level as `clk_i` in every half-period.
- R4: Code 1 is a divide ratio of 1. `clk_o` is high during the high phase of `clk_i` and low during its low phase.
- R5: Each output period starts high. It stays high for `ceil((h+1)/2)` half-periods and is low for the rest of the period.
- R6: When `h+1` is odd, successive output periods start alternately on a rising edge and on a falling edge of `clk_i`.
- R7: A code change takes effect only at the start of the next output period. The period already running completes with the old code.
- R8: `ce_o` is high for exactly those `clk_i` cycles in which an output period begins. Over `2*(h+1)` consecutive cycles it is high exactly 4 times.
- R9: The all-ones code gives the longest period, `2^CODE_W` half-periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_i | input | CODE_W | Divider code `h`: 0 selects bypass, otherwise the period is `h+1` half-periods |
| clk_o | output | 1 | Divided clock |
| ce_o | output | 1 | High during each `clk_i` cycle in which an output period starts |

## Verification
The hardest case to reach is a code change that arrives part way through a period with an odd half-period count. In that case the boundary where the new code must take effect falls on a falling edge of the source clock. The stimulus waits for a rising edge of `clk_o` to find the phase of the period. It then changes the code a chosen number of half-cycles later and measures the time to the next two output edges. A behavioural half-period model also compares the output level in both phases of every source cycle. This shows that the old period was not cut short.

// File: rtl/halfstep_pkg.sv
`timescale 1ns/1ps
package halfstep_pkg;
  // output level for the two half-slots of one source cycle
  typedef struct packed {
    logic lvl_rise;  // slot after the rising edge
    logic lvl_fall;  // slot after the falling edge
    logic begins;    // a period starts in this cycle
  } slot_pair_t;
endpackage

// File: rtl/halfstep_period.sv
`timescale 1ns/1ps
module halfstep_period #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned PW = CODE_W + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [PW-1:0]     per_o
);
  // code 0 (bypass) behaves like code 1: two half-slots per period
  always_comb begin
    if (code_i == '0) per_o = PW'(2);
    else              per_o = {1'b0, code_i} + PW'(1);
  end
endmodule

// File: rtl/halfstep_seq.sv
`timescale 1ns/1ps
module halfstep_seq #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned PW = CODE_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PW-1:0]             new_per_i,
  output halfstep_pkg::slot_pair_t  slots_o,
  output logic [PW-1:0]             cnt_o,
  output logic [PW-1:0]             per_o
);
  logic [PW-1:0] cnt_q, per_q;
  logic [PW-1:0] p0, p1, n1, n2, inc0, inc1;
  logic          start0, start1;

  function automatic logic [PW-1:0] high_len(input logic [PW-1:0] p);
    logic [PW:0] t;
    t = {1'b0, p} + (PW+1)'(1);
    return t[PW:1];
  endfunction

  always_comb begin
    start0 = (cnt_q == '0);
    p0     = start0 ? new_per_i : per_q;
    inc0   = cnt_q + PW'(1);
    n1     = (inc0 >= p0) ? '0 : inc0;
    start1 = (n1 == '0);
    p1     = start1 ? new_per_i : p0;
    inc1   = n1 + PW'(1);
    n2     = (inc1 >= p1) ? '0 : inc1;
    slots_o.lvl_rise = (cnt_q < high_len(p0));
    slots_o.lvl_fall = (n1 < high_len(p1));
    slots_o.begins   = start0 | start1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= PW'(2);
    end else begin
      cnt_q <= n2;
      per_q <= p1;
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
endmodule

// File: rtl/halfstep_edge.sv
`timescale 1ns/1ps
module halfstep_edge (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  halfstep_pkg::slot_pair_t slots_i,
  output logic                     clk_o,
  output logic                     ce_o
);
  logic rise_q, fall_q, lvl_fall_q, ce_q;

  // only one flop toggles per source edge, so the xor output is glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q     <= 1'b0;
      lvl_fall_q <= 1'b0;
      ce_q       <= 1'b0;
    end else begin
      rise_q     <= fall_q ^ slots_i.lvl_rise;
      lvl_fall_q <= slots_i.lvl_fall;
      ce_q       <= slots_i.begins;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= rise_q ^ lvl_fall_q;
  end

  assign clk_o = rise_q ^ fall_q;
  assign ce_o  = ce_q;
endmodule

// File: rtl/halfstep_clkdiv.sv
`timescale 1ns/1ps
module halfstep_clkdiv #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              clk_o,
  output logic              ce_o
);
  localparam int unsigned PW = CODE_W + 1;

  logic [PW-1:0]            new_per;
  logic [PW-1:0]            cnt_q;
  logic [PW-1:0]            per_q;
  halfstep_pkg::slot_pair_t slots;

  halfstep_period #(.CODE_W(CODE_W)) i_period (
    .code_i (code_i),
    .per_o  (new_per)
  );

  halfstep_seq #(.CODE_W(CODE_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .new_per_i (new_per),
    .slots_o   (slots),
    .cnt_o     (cnt_q),
    .per_o     (per_q)
  );

  halfstep_edge i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slots_i (slots),
    .clk_o   (clk_o),
    .ce_o    (ce_o)
  );
endmodule

// File: rtl/halfstep_chk.sv
`timescale 1ns/1ps
module halfstep_chk #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned PW = CODE_W + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clk_o,
  input logic          ce_o,
  input logic [PW-1:0] cnt_q,
  input logic [PW-1:0] per_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!clk_o && !ce_o));

  // R2
  pos_in_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per_q);

  // R9
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q >= PW'(2)) && ({1'b0, per_q} <= (PW+1)'(2**CODE_W)));

  // R7
  switch_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q != $past(per_q)) |-> ce_o);

  // R8
  ce_near_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |-> (cnt_q <= PW'(2)));
endmodule

bind halfstep_clkdiv halfstep_chk #(.CODE_W(CODE_W)) i_halfstep_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clk_o  (clk_o),
  .ce_o   (ce_o),
  .cnt_q  (cnt_q),
  .per_q  (per_q)
);

// File: tb/test_halfstep_clkdiv.sv
`timescale 1ns/1ps
module test_halfstep_clkdiv;
  localparam int CODE_W = 4;
  localparam real TCLK  = 20.0;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic [CODE_W-1:0] code_i = '0;
  logic              clk_o, ce_o;

  int checks = 0;
  int errors = 0;
  string model_tag = "R5";

  halfstep_clkdiv #(.CODE_W(CODE_W)) i_halfstep_clkdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (code_i),
    .clk_o  (clk_o),
    .ce_o   (ce_o)
  );

  always #(TCLK/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural half-period reference
  int ph = 0;
  int per = 2;
  bit ea = 0, eb = 0, ece = 0;
  bit lv0, lv1, st;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      ph = 0; per = 2; ea = 0; eb = 0; ece = 0;
    end else begin
      st = 0;
      for (int s = 0; s < 2; s++) begin
        if (ph == 0) begin
          per = (code_i == 0) ? 2 : int'(code_i) + 1;
          st = 1;
        end
        if (s == 0) lv0 = (ph < (per + 1) / 2);
        else        lv1 = (ph < (per + 1) / 2);
        ph = ph + 1;
        if (ph >= per) ph = 0;
      end
      ea = lv0; eb = lv1; ece = st;
    end
  end

  always @(posedge clk_i) begin
    #5;
    chk(clk_o == (rst_ni ? ea : 1'b0), model_tag, "level after rising edge",
        real'(clk_o), real'(rst_ni ? ea : 1'b0));
    chk(ce_o == (rst_ni ? ece : 1'b0), "R8", "enable pulse",
        real'(ce_o), real'(rst_ni ? ece : 1'b0));
  end

  always @(negedge clk_i) begin
    #5;
    chk(clk_o == (rst_ni ? eb : 1'b0), model_tag, "level after falling edge",
        real'(clk_o), real'(rst_ni ? eb : 1'b0));
  end

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic set_code(input int c);
    @(negedge clk_i);
    code_i = CODE_W'(c);
  endtask

  task automatic measure(input int c, input string tag);
    realtime t0, t1, t2;
    int p;
    p = (c == 0) ? 2 : c + 1;
    set_code(c);
    repeat (40) @(posedge clk_i);
    @(posedge clk_o); t0 = $realtime;
    @(negedge clk_o); t1 = $realtime;
    @(posedge clk_o); t2 = $realtime;
    chk(near(t2 - t0, p * TCLK / 2), tag, "output period", t2 - t0, p * TCLK / 2);
    chk(near(t1 - t0, ((p + 1) / 2) * TCLK / 2), "R5", "high time",
        t1 - t0, ((p + 1) / 2) * TCLK / 2);
  endtask

  task automatic count_ce(input int c);
    int n, p;
    p = (c == 0) ? 2 : c + 1;
    set_code(c);
    repeat (40) @(posedge clk_i);
    n = 0;
    for (int k = 0; k < 2 * p; k++) begin
      @(posedge clk_i); #5;
      if (ce_o) n++;
    end
    chk(n == 4, "R8", "enable pulses in 2*(h+1) cycles", n, 4);
  endtask

  initial begin
    realtime tp, ta, tb;
    logic x0, x1;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #5 chk(!clk_o && !ce_o, "R1", "outputs in reset (high phase)", clk_o, 0);
    @(negedge clk_i);
    #5 chk(!clk_o && !ce_o, "R1", "outputs in reset (low phase)", clk_o, 0);
    code_i = 3;
    @(negedge clk_i); #3 rst_ni = 1'b1;

    model_tag = "R3"; measure(0, "R3");
    model_tag = "R4"; measure(1, "R4");
    model_tag = "R5";
    measure(2, "R2");
    measure(3, "R2");
    measure(4, "R2");
    measure(6, "R2");
    measure(9, "R2");
    measure(15, "R9");

    // R6: odd period count alternates start edge
    set_code(2);
    repeat (20) @(posedge clk_i);
    @(posedge clk_o); #1 x0 = clk_i;
    @(posedge clk_o); #1 x1 = clk_i;
    chk(x0 != x1, "R6", "start edges alternate", real'(x1), real'(!x0));

    count_ce(4);
    count_ce(3);
    count_ce(0);

    // R7: change in mid period, old period completes
    model_tag = "R7";
    set_code(9);
    repeat (30) @(posedge clk_i);
    @(posedge clk_o); tp = $realtime;
    @(negedge clk_i); @(negedge clk_i);
    code_i = 2;
    @(posedge clk_o); ta = $realtime;
    @(posedge clk_o); tb = $realtime;
    chk(near(ta - tp, 100.0), "R7", "old period kept", ta - tp, 100.0);
    chk(near(tb - ta, 30.0), "R7", "new period adopted", tb - ta, 30.0);
    // R7: odd old period, change lands near a falling-edge boundary
    set_code(4);
    repeat (30) @(posedge clk_i);
    @(posedge clk_o); tp = $realtime;
    @(negedge clk_i);
    code_i = 6;
    @(posedge clk_o); ta = $realtime;
    @(posedge clk_o); tb = $realtime;
    chk(near(ta - tp, 50.0), "R7", "odd old period kept", ta - tp, 50.0);
    chk(near(tb - ta, 70.0), "R7", "odd new period adopted", tb - ta, 70.0);

    // R1: asynchronous reset in mid run
    model_tag = "R5";
    set_code(5);
    repeat (17) @(posedge clk_i);
    #3 rst_ni = 1'b0;
    #1 chk(!clk_o && !ce_o, "R1", "outputs low right after async reset", clk_o, 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #3 rst_ni = 1'b1;
    measure(5, "R2");

    repeat (5) @(posedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * TCLK);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected none");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule